// File: doc/BRIEF.md
# Programmed-I/O SPI NOR Flash Controller

This block lets software run a serial NOR flash one operation at a time through a small byte-wide register window. A write to the command register starts one transaction: fetch one data byte, fetch the flash status byte, send a freely composed command of up to 48 bits, program one data byte, or write the flash status register. The trigger bit stays visible while the transaction runs and clears itself when it is finished, so software polls that register to learn when the operation is complete.

The controller drives chip select, serial clock and MOSI in SPI mode 0 and samples MISO. The 24-bit flash address sits in three byte registers and can step forward by one after each byte read or byte write, so a run of bytes needs only repeated triggers. The command register accepts nothing until a key value has been written to the protect register.

Register map (4-bit index, 8-bit data): 0 command, 1 bit count, 2 captured status (read-only), 3 read data (read-only), 4/5/6 address bits 7:0 / 15:8 / 23:16, 7 write data, 8..13 command bytes 0..5, 14 protect key. Index 15 reads as zero.

Top module: `spinor_pio`

## Requirements
- R1: Command bit 0 starts a byte read, bit 1 a status read, bit 2 a composed command, bit 4 a byte program, bit 5 a status-register write; the started bit reads back as 1 while the transaction runs and reads 0 once it has completed, with chip select high by then.
- R2: Until the protect register holds 0x30, a command write is ignored: the command register stays 0 and chip select never goes low.
- R3: A byte read sends 0x03 and the address bits 23..0 MSB first in one 40-clock frame and stores the 8 bits sampled during the last 8 clocks in the read-data register.
- R4: A status read sends 0x05 in one 16-clock frame and stores the 8 bits sampled during the last 8 clocks in the status register, leaving read data untouched.
- R5: A composed command sends exactly as many bits as the bit-count register holds, starting at bit 7 of command byte 5 and running down through bytes 4, 3 and onward; counts above 48 send 48 bits and a count of 0 sends no frame and completes at once.
- R6: A byte program sends 0x06 alone in an 8-clock frame, then 0x02, the 24-bit address and the write-data byte in a 40-clock frame; chip select is high for at least two system clocks between frames.
- R7: A status-register write sends 0x06 alone in an 8-clock frame, then 0x01 followed by the write-data byte in a 16-clock frame.
- R8: When command bit 7 is set with a read or program trigger, the address registers advance by one after the transfer, wrapping from 0xFFFFFF to 0; without bit 7 the address is unchanged.
- R9: A command write made while a trigger is still set is ignored and starts nothing.
- R10: If several trigger bits are written together, only the lowest-numbered one is run and read back.
- R11: Serial clock is low whenever chip select is high, each clock phase lasts CLK_DIV/2 system clocks, and MOSI changes only when the serial clock falls.
- R12: After reset every register reads 0, chip select is high and the serial clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 4 | Register index for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_rdata | output | 8 | Register read data for reg_addr, combinational |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
A sequencer stuck in the wrong phase shows up as a trigger bit that never clears or a frame of the wrong length, visible within one frame time of the trigger. A mis-aligned shift register shows as a wrong opcode on the first eight serial clocks, and a mis-captured byte shows in read data or status as soon as the trigger clears. A broken protect gate or busy guard shows either as a chip-select fall where none is allowed or as a second frame; the bench counts frames at the pins and compares every bit, so each of these is caught in the transaction that exposes it.

// File: rtl/spinor_pkg.sv
package spinor_pkg;

    localparam int PD_BYTES = 6;
    localparam int FRAME_W  = PD_BYTES * 8;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_RD,
        OP_RS,
        OP_PRG,
        OP_WR,
        OP_WS
    } op_e;

    // register indices
    localparam logic [3:0] REG_CMD   = 4'd0;
    localparam logic [3:0] REG_BCNT  = 4'd1;
    localparam logic [3:0] REG_STAT  = 4'd2;
    localparam logic [3:0] REG_RDAT  = 4'd3;
    localparam logic [3:0] REG_ADR0  = 4'd4;
    localparam logic [3:0] REG_ADR1  = 4'd5;
    localparam logic [3:0] REG_ADR2  = 4'd6;
    localparam logic [3:0] REG_WDAT  = 4'd7;
    localparam logic [3:0] REG_PD0   = 4'd8;
    localparam logic [3:0] REG_KEY   = 4'd14;

    // command bits
    localparam int CB_RD   = 0;
    localparam int CB_RS   = 1;
    localparam int CB_PRG  = 2;
    localparam int CB_WR   = 4;
    localparam int CB_WS   = 5;
    localparam int CB_AINC = 7;
    localparam logic [7:0] TRIG_MASK = 8'h37;

    localparam logic [7:0] UNLOCK_KEY = 8'h30;

    // flash opcodes
    localparam logic [7:0] FOP_READ = 8'h03;
    localparam logic [7:0] FOP_RDSR = 8'h05;
    localparam logic [7:0] FOP_WREN = 8'h06;
    localparam logic [7:0] FOP_PROG = 8'h02;
    localparam logic [7:0] FOP_WRSR = 8'h01;

endpackage

// File: rtl/spinor_shift.sv
module spinor_shift #(
    parameter int CLK_DIV = 4,
    parameter int GAP_CYC = 2,
    parameter int FRAME_W = 48,
    localparam int HALF   = CLK_DIV / 2,
    localparam int HCW    = (HALF > 1) ? $clog2(HALF) : 1,
    localparam int LW     = $clog2(FRAME_W + 1),
    localparam int GW     = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [FRAME_W-1:0] tx_i,
    input  logic [LW-1:0]      len_i,
    input  logic               miso_i,
    output logic               cs_n_o,
    output logic               sclk_o,
    output logic               mosi_o,
    output logic               done_o,
    output logic [7:0]         rx_o
);

    typedef enum logic [1:0] {E_IDLE, E_RUN, E_GAP} est_e;

    typedef struct packed {
        est_e               state;
        logic [HCW-1:0]     hcnt;
        logic [LW-1:0]      left;
        logic [GW-1:0]      gcnt;
        logic [FRAME_W-1:0] shreg;
        logic [7:0]         rx;
        logic               cs_n;
        logic               sclk;
        logic               mosi;
        logic               done;
    } eng_s;

    eng_s eng_d, eng_q;

    always_comb begin
        eng_d      = eng_q;
        eng_d.done = 1'b0;
        unique case (eng_q.state)
            E_IDLE: begin
                if (start_i && (len_i != '0)) begin
                    eng_d.state = E_RUN;
                    eng_d.cs_n  = 1'b0;
                    eng_d.sclk  = 1'b0;
                    eng_d.mosi  = tx_i[FRAME_W-1];
                    eng_d.shreg = tx_i;
                    eng_d.left  = len_i;
                    eng_d.hcnt  = '0;
                    eng_d.rx    = '0;
                end
            end
            E_RUN: begin
                if (eng_q.hcnt == HCW'(HALF - 1)) begin
                    eng_d.hcnt = '0;
                    if (!eng_q.sclk) begin
                        eng_d.sclk = 1'b1;
                        eng_d.rx   = {eng_q.rx[6:0], miso_i};
                    end else begin
                        eng_d.sclk  = 1'b0;
                        eng_d.shreg = eng_q.shreg << 1;
                        eng_d.mosi  = eng_q.shreg[FRAME_W-2];
                        eng_d.left  = eng_q.left - 1'b1;
                        if (eng_q.left == LW'(1)) begin
                            eng_d.state = E_GAP;
                            eng_d.cs_n  = 1'b1;
                            eng_d.mosi  = 1'b0;
                            eng_d.gcnt  = '0;
                        end
                    end
                end else begin
                    eng_d.hcnt = eng_q.hcnt + 1'b1;
                end
            end
            E_GAP: begin
                if (eng_q.gcnt == GW'(GAP_CYC - 1)) begin
                    eng_d.state = E_IDLE;
                    eng_d.done  = 1'b1;
                end else begin
                    eng_d.gcnt = eng_q.gcnt + 1'b1;
                end
            end
            default: eng_d.state = E_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q       <= '0;
            eng_q.state <= E_IDLE;
            eng_q.cs_n  <= 1'b1;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign cs_n_o = eng_q.cs_n;
    assign sclk_o = eng_q.sclk;
    assign mosi_o = eng_q.mosi;
    assign done_o = eng_q.done;
    assign rx_o   = eng_q.rx;

endmodule

// File: rtl/spinor_seq.sv
module spinor_seq
    import spinor_pkg::*;
#(
    parameter int FW  = FRAME_W,
    localparam int LW = $clog2(FW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_i,
    input  op_e           op_i,
    input  logic [23:0]   addr_i,
    input  logic [7:0]    wdata_i,
    input  logic [FW-1:0] pdata_i,
    input  logic [7:0]    cnt_i,
    input  logic          eng_done_i,
    output logic          eng_start_o,
    output logic [FW-1:0] eng_tx_o,
    output logic [LW-1:0] eng_len_o,
    output logic          fin_o
);

    typedef enum logic [1:0] {Q_IDLE, Q_F1, Q_F2} qst_e;

    typedef struct packed {
        qst_e          state;
        op_e           op;
        logic          start;
        logic [FW-1:0] tx;
        logic [LW-1:0] len;
        logic          fin;
    } seq_s;

    seq_s seq_d, seq_q;

    always_comb begin
        seq_d       = seq_q;
        seq_d.start = 1'b0;
        seq_d.fin   = 1'b0;
        unique case (seq_q.state)
            Q_IDLE: begin
                if (go_i) begin
                    seq_d.op = op_i;
                    unique case (op_i)
                        OP_RD: begin
                            seq_d.tx    = FW'({FOP_READ, addr_i}) << (FW - 32);
                            seq_d.len   = LW'(40);
                            seq_d.start = 1'b1;
                            seq_d.state = Q_F1;
                        end
                        OP_RS: begin
                            seq_d.tx    = FW'(FOP_RDSR) << (FW - 8);
                            seq_d.len   = LW'(16);
                            seq_d.start = 1'b1;
                            seq_d.state = Q_F1;
                        end
                        OP_PRG: begin
                            if (cnt_i == 8'd0) begin
                                seq_d.fin = 1'b1;
                            end else begin
                                seq_d.tx    = pdata_i;
                                seq_d.len   = (cnt_i > 8'(FW)) ? LW'(FW) : LW'(cnt_i);
                                seq_d.start = 1'b1;
                                seq_d.state = Q_F1;
                            end
                        end
                        OP_WR, OP_WS: begin
                            seq_d.tx    = FW'(FOP_WREN) << (FW - 8);
                            seq_d.len   = LW'(8);
                            seq_d.start = 1'b1;
                            seq_d.state = Q_F1;
                        end
                        default: seq_d.fin = 1'b1;
                    endcase
                end
            end
            Q_F1: begin
                if (eng_done_i) begin
                    if (seq_q.op == OP_WR) begin
                        seq_d.tx    = FW'({FOP_PROG, addr_i, wdata_i}) << (FW - 40);
                        seq_d.len   = LW'(40);
                        seq_d.start = 1'b1;
                        seq_d.state = Q_F2;
                    end else if (seq_q.op == OP_WS) begin
                        seq_d.tx    = FW'({FOP_WRSR, wdata_i}) << (FW - 16);
                        seq_d.len   = LW'(16);
                        seq_d.start = 1'b1;
                        seq_d.state = Q_F2;
                    end else begin
                        seq_d.fin   = 1'b1;
                        seq_d.state = Q_IDLE;
                    end
                end
            end
            Q_F2: begin
                if (eng_done_i) begin
                    seq_d.fin   = 1'b1;
                    seq_d.state = Q_IDLE;
                end
            end
            default: seq_d.state = Q_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q       <= '0;
            seq_q.state <= Q_IDLE;
            seq_q.op    <= OP_NONE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign eng_start_o = seq_q.start;
    assign eng_tx_o    = seq_q.tx;
    assign eng_len_o   = seq_q.len;
    assign fin_o       = seq_q.fin;

endmodule

// File: rtl/spinor_pio.sv
module spinor_pio
    import spinor_pkg::*;
#(
    parameter int CLK_DIV = 4,
    parameter int GAP_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] reg_addr,
    input  logic [7:0] reg_wdata,
    input  logic       reg_we,
    output logic [7:0] reg_rdata,
    output logic       spi_cs_n,
    output logic       spi_sclk,
    output logic       spi_mosi,
    input  logic       spi_miso
);

    localparam int LW = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic [7:0]                cmd;
        logic [7:0]                bcnt;
        logic [7:0]                stat;
        logic [7:0]                rdat;
        logic [23:0]               addr;
        logic [7:0]                wdat;
        logic [PD_BYTES-1:0][7:0]  pd;
        logic [7:0]                key;
        logic                      go;
        op_e                       op;
    } regs_s;

    regs_s rf_d, rf_q;

    logic [7:0]         trig;
    logic               unlocked;
    logic               fin;
    logic               eng_start;
    logic [FRAME_W-1:0] eng_tx;
    logic [LW-1:0]      eng_len;
    logic               eng_done;
    logic [7:0]         eng_rx;

    assign trig     = rf_q.cmd & TRIG_MASK;
    assign unlocked = (rf_q.key == UNLOCK_KEY);

    always_comb begin
        rf_d    = rf_q;
        rf_d.go = 1'b0;
        if (reg_we) begin
            unique case (reg_addr)
                REG_CMD: begin
                    if (unlocked && (trig == 8'd0)) begin
                        rf_d.cmd = reg_wdata & 8'h80;
                        if (reg_wdata[CB_RD]) begin
                            rf_d.cmd[CB_RD] = 1'b1;
                            rf_d.op = OP_RD;
                            rf_d.go = 1'b1;
                        end else if (reg_wdata[CB_RS]) begin
                            rf_d.cmd[CB_RS] = 1'b1;
                            rf_d.op = OP_RS;
                            rf_d.go = 1'b1;
                        end else if (reg_wdata[CB_PRG]) begin
                            rf_d.cmd[CB_PRG] = 1'b1;
                            rf_d.op = OP_PRG;
                            rf_d.go = 1'b1;
                        end else if (reg_wdata[CB_WR]) begin
                            rf_d.cmd[CB_WR] = 1'b1;
                            rf_d.op = OP_WR;
                            rf_d.go = 1'b1;
                        end else if (reg_wdata[CB_WS]) begin
                            rf_d.cmd[CB_WS] = 1'b1;
                            rf_d.op = OP_WS;
                            rf_d.go = 1'b1;
                        end
                    end
                end
                REG_BCNT: rf_d.bcnt = reg_wdata;
                REG_ADR0: rf_d.addr[7:0]   = reg_wdata;
                REG_ADR1: rf_d.addr[15:8]  = reg_wdata;
                REG_ADR2: rf_d.addr[23:16] = reg_wdata;
                REG_WDAT: rf_d.wdat = reg_wdata;
                REG_KEY:  rf_d.key  = reg_wdata;
                default: ;
            endcase
            for (int i = 0; i < PD_BYTES; i++) begin
                if (reg_addr == REG_PD0 + 4'(i)) begin
                    rf_d.pd[i] = reg_wdata;
                end
            end
        end
        if (fin) begin
            rf_d.cmd = rf_q.cmd & 8'h80;
            unique case (rf_q.op)
                OP_RD: begin
                    rf_d.rdat = eng_rx;
                    if (rf_q.cmd[CB_AINC]) rf_d.addr = rf_q.addr + 24'd1;
                end
                OP_RS: rf_d.stat = eng_rx;
                OP_WR: begin
                    if (rf_q.cmd[CB_AINC]) rf_d.addr = rf_q.addr + 24'd1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rf_q    <= '0;
            rf_q.op <= OP_NONE;
        end else begin
            rf_q <= rf_d;
        end
    end

    always_comb begin
        reg_rdata = 8'd0;
        unique case (reg_addr)
            REG_CMD:  reg_rdata = rf_q.cmd;
            REG_BCNT: reg_rdata = rf_q.bcnt;
            REG_STAT: reg_rdata = rf_q.stat;
            REG_RDAT: reg_rdata = rf_q.rdat;
            REG_ADR0: reg_rdata = rf_q.addr[7:0];
            REG_ADR1: reg_rdata = rf_q.addr[15:8];
            REG_ADR2: reg_rdata = rf_q.addr[23:16];
            REG_WDAT: reg_rdata = rf_q.wdat;
            REG_KEY:  reg_rdata = rf_q.key;
            default: ;
        endcase
        for (int i = 0; i < PD_BYTES; i++) begin
            if (reg_addr == REG_PD0 + 4'(i)) reg_rdata = rf_q.pd[i];
        end
    end

    spinor_seq #(.FW(FRAME_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .go_i        (rf_q.go),
        .op_i        (rf_q.op),
        .addr_i      (rf_q.addr),
        .wdata_i     (rf_q.wdat),
        .pdata_i     (rf_q.pd),
        .cnt_i       (rf_q.bcnt),
        .eng_done_i  (eng_done),
        .eng_start_o (eng_start),
        .eng_tx_o    (eng_tx),
        .eng_len_o   (eng_len),
        .fin_o       (fin)
    );

    spinor_shift #(
        .CLK_DIV (CLK_DIV),
        .GAP_CYC (GAP_CYC),
        .FRAME_W (FRAME_W)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (eng_start),
        .tx_i    (eng_tx),
        .len_i   (eng_len),
        .miso_i  (spi_miso),
        .cs_n_o  (spi_cs_n),
        .sclk_o  (spi_sclk),
        .mosi_o  (spi_mosi),
        .done_o  (eng_done),
        .rx_o    (eng_rx)
    );

endmodule

module spinor_pio_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       sclk,
    input logic       mosi,
    input logic       unlocked,
    input logic [7:0] trig
);

    // R11
    mosi_hold_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(mosi));

    // R11
    sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R2
    locked_no_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && (trig == 8'd0)) |-> cs_n);

    // R1
    trig_clear_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(|trig) |-> cs_n);

    // R10
    single_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(trig));

    // R6
    cs_gap_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> cs_n);

endmodule

bind spinor_pio spinor_pio_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (spi_cs_n),
    .sclk     (spi_sclk),
    .mosi     (spi_mosi),
    .unlocked (unlocked),
    .trig     (trig)
);

// File: tb/spinor_pio_bench.sv
module spinor_pio_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] reg_addr = 4'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_rdata;
    logic       spi_cs_n;
    logic       spi_sclk;
    logic       spi_mosi;
    logic       spi_miso = 1'b0;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    spinor_pio #(.CLK_DIV(4), .GAP_CYC(2)) u_spinor_pio (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata),
        .spi_cs_n  (spi_cs_n),
        .spi_sclk  (spi_sclk),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso)
    );

    // ---------------- flash model ----------------
    logic [63:0] cur_bits = '0;
    int          cur_len = 0;
    logic [63:0] fr_bits [0:31];
    int          fr_len  [0:31];
    int          nfr = 0;
    int          ncs_fall = 0;
    logic [7:0]  model_status = 8'h00;
    logic [7:0]  resp = 8'h00;
    int          rmode = 0;

    function automatic logic [7:0] mem_byte(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
    endfunction

    always @(negedge spi_cs_n) begin
        cur_bits = '0;
        cur_len  = 0;
        rmode    = 0;
        ncs_fall++;
    end

    always @(posedge spi_cs_n) begin
        if (cur_len > 0 && nfr < 32) begin
            fr_bits[nfr] = cur_bits;
            fr_len[nfr]  = cur_len;
            nfr++;
        end
    end

    always @(posedge spi_sclk) begin
        if (!spi_cs_n) begin
            cur_bits = {cur_bits[62:0], spi_mosi};
            cur_len++;
        end
    end

    always @(negedge spi_sclk) begin
        if (!spi_cs_n) begin
            if (cur_len == 8 && cur_bits[7:0] == 8'h05) begin
                rmode = 1;
                resp  = model_status;
            end
            if (cur_len == 32 && cur_bits[31:24] == 8'h03) begin
                rmode = 2;
                resp  = mem_byte(cur_bits[23:0]);
            end
            if (rmode == 1 && cur_len >= 8 && cur_len < 16)
                spi_miso = resp[15 - cur_len];
            else if (rmode == 2 && cur_len >= 32 && cur_len < 40)
                spi_miso = resp[39 - cur_len];
            else
                spi_miso = 1'b0;
        end
    end

    // pin timing monitors
    int hi_run = 0, hi_min = 1000, hi_max = 0;
    int cs_run = 0, gap_min = 1000;
    always @(posedge clk) begin
        if (spi_sclk) hi_run++;
        else if (hi_run > 0) begin
            if (hi_run < hi_min) hi_min = hi_run;
            if (hi_run > hi_max) hi_max = hi_run;
            hi_run = 0;
        end
        if (spi_cs_n) cs_run++;
        else if (cs_run > 0) begin
            if (cs_run < gap_min) gap_min = cs_run;
            cs_run = 0;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_done(input string req);
        logic [7:0] v;
        int n;
        n = 0;
        v = 8'hFF;
        while ((v & 8'h37) != 0 && n < 3000) begin
            rd(4'd0, v);
            n++;
        end
        chk({req, " trigger clears"}, 64'(v & 8'h37), 64'h0);
    endtask

    task automatic set_addr(input logic [23:0] a);
        wr(4'd4, a[7:0]);
        wr(4'd5, a[15:8]);
        wr(4'd6, a[23:16]);
    endtask

    task automatic get_addr(output logic [23:0] a);
        logic [7:0] b0, b1, b2;
        rd(4'd4, b0);
        rd(4'd5, b1);
        rd(4'd6, b2);
        a = {b2, b1, b0};
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset;
        logic [7:0] v;
        for (int i = 0; i < 16; i++) begin
            rd(4'(i), v);
            chk("R12 register zero after reset", 64'(v), 64'h0);
        end
        chk("R12 cs high after reset", 64'(spi_cs_n), 64'h1);
        chk("R12 sclk low after reset", 64'(spi_sclk), 64'h0);
    endtask

    task automatic t_locked;
        logic [7:0] v;
        int f0;
        f0 = ncs_fall;
        wr(4'd0, 8'h01);
        rd(4'd0, v);
        chk("R2 cmd ignored while locked", 64'(v), 64'h0);
        repeat (200) @(posedge clk);
        chk("R2 no chip select while locked", 64'(ncs_fall - f0), 64'h0);
        wr(4'd14, 8'h30);
    endtask

    task automatic t_read;
        logic [7:0] v;
        logic [23:0] a;
        int f0;
        set_addr(24'h123456);
        f0 = nfr;
        wr(4'd0, 8'h01);
        rd(4'd0, v);
        chk("R1 read trigger visible while busy", 64'(v), 64'h01);
        wait_done("R1 read");
        chk("R3 one frame", 64'(nfr - f0), 64'h1);
        chk("R3 frame length 40", 64'(fr_len[f0]), 64'd40);
        chk("R3 frame bits", fr_bits[f0], {24'h0, 8'h03, 24'h123456, 8'h00});
        rd(4'd3, v);
        chk("R3 read data", 64'(v), 64'(mem_byte(24'h123456)));
        get_addr(a);
        chk("R8 no advance without flag", 64'(a), 64'h123456);
        chk("R11 sclk high phase min", 64'(hi_min), 64'd2);
        chk("R11 sclk high phase max", 64'(hi_max), 64'd2);
    endtask

    task automatic t_autoinc;
        logic [7:0] v;
        logic [23:0] a;
        set_addr(24'h00FFFF);
        wr(4'd0, 8'h81);
        wait_done("R8 read 1");
        rd(4'd3, v);
        chk("R8 byte 1", 64'(v), 64'(mem_byte(24'h00FFFF)));
        get_addr(a);
        chk("R8 address advanced", 64'(a), 64'h010000);
        wr(4'd0, 8'h81);
        wait_done("R8 read 2");
        rd(4'd3, v);
        chk("R8 byte 2 from advanced address", 64'(v), 64'(mem_byte(24'h010000)));
        set_addr(24'hFFFFFF);
        wr(4'd0, 8'h81);
        wait_done("R8 wrap");
        get_addr(a);
        chk("R8 address wraps", 64'(a), 64'h000000);
    endtask

    task automatic t_status;
        logic [7:0] v, r0;
        int f0;
        rd(4'd3, r0);
        model_status = 8'hA5;
        f0 = nfr;
        wr(4'd0, 8'h02);
        wait_done("R4 status");
        chk("R4 frame length 16", 64'(fr_len[f0]), 64'd16);
        chk("R4 frame bits", fr_bits[f0], 64'h0500);
        rd(4'd2, v);
        chk("R4 status captured", 64'(v), 64'hA5);
        rd(4'd3, v);
        chk("R4 read data untouched", 64'(v), 64'(r0));
    endtask

    task automatic t_prg;
        int f0;
        wr(4'd13, 8'h06);
        wr(4'd1, 8'd8);
        f0 = nfr;
        wr(4'd0, 8'h04);
        wait_done("R5 count 8");
        chk("R5 count 8 length", 64'(fr_len[f0]), 64'd8);
        chk("R5 count 8 bits", fr_bits[f0], 64'h06);
        wr(4'd13, 8'h20);
        wr(4'd12, 8'hAB);
        wr(4'd11, 8'hCD);
        wr(4'd10, 8'hEF);
        wr(4'd9, 8'h11);
        wr(4'd8, 8'h22);
        wr(4'd1, 8'd32);
        f0 = nfr;
        wr(4'd0, 8'h04);
        wait_done("R5 count 32");
        chk("R5 count 32 length", 64'(fr_len[f0]), 64'd32);
        chk("R5 count 32 bits", fr_bits[f0], 64'h20ABCDEF);
        wr(4'd1, 8'd60);
        f0 = nfr;
        wr(4'd0, 8'h04);
        wait_done("R5 count clamp");
        chk("R5 clamped length", 64'(fr_len[f0]), 64'd48);
        chk("R5 clamped bits", fr_bits[f0], 64'h20ABCDEF1122);
        wr(4'd1, 8'd0);
        f0 = ncs_fall;
        wr(4'd0, 8'h04);
        wait_done("R5 count 0");
        chk("R5 count 0 sends no frame", 64'(ncs_fall - f0), 64'h0);
    endtask

    task automatic t_write;
        logic [23:0] a;
        int f0;
        set_addr(24'h000010);
        wr(4'd7, 8'h5C);
        f0 = nfr;
        gap_min = 1000;
        wr(4'd0, 8'h90);
        wait_done("R6 program");
        chk("R6 two frames", 64'(nfr - f0), 64'd2);
        chk("R6 enable frame length", 64'(fr_len[f0]), 64'd8);
        chk("R6 enable frame bits", fr_bits[f0], 64'h06);
        chk("R6 data frame length", 64'(fr_len[f0+1]), 64'd40);
        chk("R6 data frame bits", fr_bits[f0+1], {24'h0, 8'h02, 24'h000010, 8'h5C});
        chk("R6 gap at least two clocks", 64'(gap_min >= 2), 64'h1);
        get_addr(a);
        chk("R8 advance after program", 64'(a), 64'h000011);
    endtask

    task automatic t_wrsr;
        int f0;
        wr(4'd7, 8'h9C);
        f0 = nfr;
        wr(4'd0, 8'h20);
        wait_done("R7 status write");
        chk("R7 two frames", 64'(nfr - f0), 64'd2);
        chk("R7 enable frame bits", fr_bits[f0], 64'h06);
        chk("R7 second frame length", 64'(fr_len[f0+1]), 64'd16);
        chk("R7 second frame bits", fr_bits[f0+1], 64'h019C);
    endtask

    task automatic t_busy;
        logic [7:0] v;
        int f0;
        model_status = 8'h3C;
        set_addr(24'h000200);
        f0 = nfr;
        wr(4'd0, 8'h01);
        wr(4'd0, 8'h02);
        rd(4'd0, v);
        chk("R9 busy write ignored", 64'(v), 64'h01);
        wait_done("R9 busy");
        repeat (100) @(posedge clk);
        chk("R9 only one frame", 64'(nfr - f0), 64'd1);
        rd(4'd2, v);
        chk("R9 status unchanged", 64'(v), 64'hA5);
    endtask

    task automatic t_priority;
        logic [7:0] v;
        int f0;
        f0 = nfr;
        wr(4'd0, 8'h37);
        rd(4'd0, v);
        chk("R10 lowest trigger kept", 64'(v), 64'h01);
        wait_done("R10 priority");
        chk("R10 one frame", 64'(nfr - f0), 64'd1);
        chk("R10 read opcode sent", 64'(fr_bits[f0][39:32]), 64'h03);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_locked();
        t_read();
        t_autoinc();
        t_status();
        t_prg();
        t_write();
        t_wrsr();
        t_busy();
        t_priority();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule